// File: doc/BRIEF.md
# Receive Buffer Flow-Control Unit

The unit keeps a count of free receive buffers (credits) for each of several DMA channel pairs. Pair k serves channels 2k and 2k+1. The even channel receives and the odd channel transmits, and only the receiving side consumes credits. Software adds credits by writing a count to the pair's allocation register. The DMA engine pulses `desc_done[k]` each time it completes a receive descriptor, and each pulse removes one credit. From the credit count and two programmable thresholds, the unit raises `pause[k]` so that the sender upstream holds off while buffers are scarce.

Each pair runs a small state machine with four named states:
- **ST_OFF**: the pair or the whole controller is disabled.
- **ST_FORCED**: software has forced the pair open.
- **ST_FLOWING**: traffic is allowed.
- **ST_PAUSED**: pause is requested.

The transitions are:
- **T_DISABLE**: any state goes to ST_OFF when the enable is lost. This transition has the highest priority.
- **T_FORCE**: any enabled state goes to ST_FORCED while the force flag is set.
- **T_START**: ST_OFF or ST_FORCED goes to ST_FLOWING.
- **T_STARVE**: ST_FLOWING goes to ST_PAUSED when credits are below the low threshold.
- **T_RECOVER**: ST_PAUSED goes to ST_FLOWING when credits are above the high threshold.

Software normally sets the low threshold near a third of the ring size and the high threshold near two thirds. When software disables a receive channel, it writes the force bit.

Top module: `rx_fc_unit`

## Requirements
- R1: After reset every `pause` bit is 0, and every register reads as 0.
- R2: Register map. The word at 0x00 holds the enables: bit 0 is the controller-wide enable and bit k+1 is the enable for pair k. Pair k has its low threshold at 0x04+12k, its high threshold at 0x08+12k and its allocation register at 0x0C+12k. Both thresholds read back the value written in bits CNT_W-1:0. A read of the allocation register returns the credit count in bits CNT_W-1:0 and the force flag in bit 31.
- R3: A write of N to the allocation register with bit 31 clear adds N credits, saturating at 2^CNT_W-1, and clears the force flag.
- R4: Each `desc_done[k]` pulse removes one credit, and the count saturates at 0. An allocation write and a pulse in the same cycle give a net change of N-1. Without either, the count holds.
- R5: In ST_FLOWING, a credit count strictly below the low threshold moves the pair to ST_PAUSED, and `pause` is 1 from the next clock edge. A count equal to the low threshold does not pause.
- R6: In ST_PAUSED, `pause` drops only when the credit count is strictly above the high threshold. A count at or below the high threshold keeps `pause` at 1.
- R7: A write to the allocation register with bit 31 set sets the force flag and clears the credit count. While the flag is set, `pause` is 0 from the next edge and `desc_done` pulses have no effect.
- R8: When the controller-wide enable or the pair's enable is 0, that pair's `pause` is 0 from the next edge.
- R9: Pairs are independent: writes and pulses for one pair change no other pair's credits or `pause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read byte address (combinational read) |
| rd_data | output | 32 | Register read data |
| desc_done | input | NUM_PAIRS | Per-pair receive descriptor completion pulse |
| pause | output | NUM_PAIRS | Per-pair pause request |

## Verification
The hardest cases to reach are the edges of the hysteresis band: a credit count sitting exactly on the low or the high threshold. The stimulus reaches these by adding and removing credits one at a time, so that the count sits on each threshold value before it crosses. A second hard case is an allocation write and a descriptor completion landing on the same clock edge. The stimulus drives both in one cycle and reads the net count back through the allocation register. The force path is driven while credits are below the low threshold, which shows that a completion pulse neither moves the cleared count nor brings back the pause.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_FORCED  = 2'd1,
        ST_FLOWING = 2'd2,
        ST_PAUSED  = 2'd3
    } pair_state_e;

    localparam int CFG_OFF    = 0;
    localparam int PAIR_STEP  = 12;
    localparam int FORCE_BIT  = 31;

    function automatic int lo_off(input int k);
        return 4 + PAIR_STEP * k;
    endfunction

    function automatic int hi_off(input int k);
        return 8 + PAIR_STEP * k;
    endfunction

    function automatic int alloc_off(input int k);
        return 12 + PAIR_STEP * k;
    endfunction

endpackage

// File: rtl/rxfc_regs.sv
module rxfc_regs
    import rxfc_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int CNT_W     = 8,
    parameter int ADDR_W    = 8,
    parameter int VAL_W     = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [VAL_W-1:0]                   wr_val,
    input  logic [ADDR_W-1:0]                  rd_addr,
    input  logic [NUM_PAIRS-1:0][CNT_W-1:0]    credit,
    input  logic [NUM_PAIRS-1:0]               force_q,
    output logic [31:0]                        rd_data,
    output logic                               glob_en,
    output logic [NUM_PAIRS-1:0]               pair_en,
    output logic [NUM_PAIRS-1:0][CNT_W-1:0]    lo_thr,
    output logic [NUM_PAIRS-1:0][CNT_W-1:0]    hi_thr,
    output logic [NUM_PAIRS-1:0]               alloc_stb
);

    localparam int CFG_W = NUM_PAIRS + 1;

    logic [CFG_W-1:0] cfg_q;
    logic             cfg_hit;

    assign cfg_hit = wr_en && (int'(wr_addr) == CFG_OFF);
    assign glob_en = cfg_q[0];
    assign pair_en = cfg_q[CFG_W-1:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_hit) begin
            cfg_q <= wr_val[CFG_W-1:0];
        end
    end

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair_regs
        logic lo_hit, hi_hit;

        assign lo_hit       = wr_en && (int'(wr_addr) == lo_off(k));
        assign hi_hit       = wr_en && (int'(wr_addr) == hi_off(k));
        assign alloc_stb[k] = wr_en && (int'(wr_addr) == alloc_off(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_thr[k] <= '0;
                hi_thr[k] <= '0;
            end else begin
                if (lo_hit) begin
                    lo_thr[k] <= wr_val[CNT_W-1:0];
                end
                if (hi_hit) begin
                    hi_thr[k] <= wr_val[CNT_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) == CFG_OFF) begin
            rd_data[CFG_W-1:0] = cfg_q;
        end
        for (int k = 0; k < NUM_PAIRS; k++) begin
            if (int'(rd_addr) == lo_off(k)) begin
                rd_data[CNT_W-1:0] = lo_thr[k];
            end
            if (int'(rd_addr) == hi_off(k)) begin
                rd_data[CNT_W-1:0] = hi_thr[k];
            end
            if (int'(rd_addr) == alloc_off(k)) begin
                rd_data[CNT_W-1:0] = credit[k];
                rd_data[FORCE_BIT] = force_q[k];
            end
        end
    end

endmodule

// File: rtl/rxfc_credit.sv
module rxfc_credit
    import rxfc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_stb,
    input  logic [31:0]      alloc_data,
    input  logic             done,
    output logic [CNT_W-1:0] credit,
    output logic             force_q
);

    localparam logic [31:0] MAX_VAL = (32'd1 << CNT_W) - 32'd1;

    logic [31:0]      sum;
    logic [CNT_W-1:0] credit_d;
    logic             force_d;
    logic             force_wr;

    assign force_wr = alloc_stb && alloc_data[FORCE_BIT];

    always_comb begin
        sum = 32'(credit);
        if (alloc_stb && !alloc_data[FORCE_BIT]) begin
            sum = sum + {1'b0, alloc_data[30:0]};
        end
        if (done && (sum != 32'd0)) begin
            sum = sum - 32'd1;
        end

        if (force_wr) begin
            credit_d = '0;
            force_d  = 1'b1;
        end else if (alloc_stb) begin
            credit_d = (sum > MAX_VAL) ? MAX_VAL[CNT_W-1:0] : sum[CNT_W-1:0];
            force_d  = 1'b0;
        end else if (force_q) begin
            credit_d = '0;
            force_d  = 1'b1;
        end else begin
            credit_d = sum[CNT_W-1:0];
            force_d  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            credit  <= '0;
            force_q <= 1'b0;
        end else begin
            credit  <= credit_d;
            force_q <= force_d;
        end
    end

endmodule

// File: rtl/rxfc_pair_fsm.sv
module rxfc_pair_fsm
    import rxfc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             force_q,
    input  logic [CNT_W-1:0] credit,
    input  logic [CNT_W-1:0] lo_thr,
    input  logic [CNT_W-1:0] hi_thr,
    output logic             pause
);

    pair_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_OFF;
        end else if (force_q) begin
            state_d = ST_FORCED;
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = ST_FLOWING;
                ST_FORCED:  state_d = ST_FLOWING;
                ST_FLOWING: state_d = (credit < lo_thr) ? ST_PAUSED : ST_FLOWING;
                ST_PAUSED:  state_d = (credit > hi_thr) ? ST_FLOWING : ST_PAUSED;
                default:    state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        pause = (state_q == ST_PAUSED);
    end

endmodule

// File: rtl/rx_fc_unit.sv
module rx_fc_unit
    import rxfc_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int CNT_W     = 8,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [31:0]          rd_data,
    input  logic [NUM_PAIRS-1:0] desc_done,
    output logic [NUM_PAIRS-1:0] pause
);

    localparam int VAL_W = (CNT_W > NUM_PAIRS + 1) ? CNT_W : NUM_PAIRS + 1;

    logic                            glob_en;
    logic [NUM_PAIRS-1:0]            pair_en;
    logic [NUM_PAIRS-1:0][CNT_W-1:0] lo_thr;
    logic [NUM_PAIRS-1:0][CNT_W-1:0] hi_thr;
    logic [NUM_PAIRS-1:0][CNT_W-1:0] credit;
    logic [NUM_PAIRS-1:0]            force_q;
    logic [NUM_PAIRS-1:0]            alloc_stb;

    rxfc_regs #(
        .NUM_PAIRS (NUM_PAIRS),
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W),
        .VAL_W     (VAL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_val    (wr_data[VAL_W-1:0]),
        .rd_addr   (rd_addr),
        .credit    (credit),
        .force_q   (force_q),
        .rd_data   (rd_data),
        .glob_en   (glob_en),
        .pair_en   (pair_en),
        .lo_thr    (lo_thr),
        .hi_thr    (hi_thr),
        .alloc_stb (alloc_stb)
    );

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        rxfc_credit #(
            .CNT_W (CNT_W)
        ) u_credit (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_stb  (alloc_stb[k]),
            .alloc_data (wr_data),
            .done       (desc_done[k]),
            .credit     (credit[k]),
            .force_q    (force_q[k])
        );

        rxfc_pair_fsm #(
            .CNT_W (CNT_W)
        ) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (glob_en && pair_en[k]),
            .force_q (force_q[k]),
            .credit  (credit[k]),
            .lo_thr  (lo_thr[k]),
            .hi_thr  (hi_thr[k]),
            .pause   (pause[k])
        );
    end

endmodule

// File: rtl/rxfc_checker.sv
module rxfc_checker #(
    parameter int NUM_PAIRS = 4,
    parameter int CNT_W     = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            glob_en,
    input logic [NUM_PAIRS-1:0]            pair_en,
    input logic [NUM_PAIRS-1:0][CNT_W-1:0] lo_thr,
    input logic [NUM_PAIRS-1:0][CNT_W-1:0] hi_thr,
    input logic [NUM_PAIRS-1:0][CNT_W-1:0] credit,
    input logic [NUM_PAIRS-1:0]            force_q,
    input logic [NUM_PAIRS-1:0]            alloc_stb,
    input logic [NUM_PAIRS-1:0]            desc_done,
    input logic [NUM_PAIRS-1:0]            pause
);

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_chk
        assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!alloc_stb[k] && desc_done[k] && credit[k] != '0)
                |=> credit[k] == $past(credit[k]) - CNT_W'(1));

        assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!alloc_stb[k] && !desc_done[k]) |=> $stable(credit[k]));

        assert_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!alloc_stb[k] && credit[k] == '0) |=> credit[k] == '0);

        assert_pause_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pause[k]) |-> $past(credit[k]) < $past(lo_thr[k]));

        assert_pause_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(pause[k]) && $past(glob_en && pair_en[k]) && !$past(force_q[k]))
                |-> $past(credit[k]) > $past(hi_thr[k]));

        assert_force_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
            force_q[k] |=> !pause[k]);

        assert_off_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(glob_en && pair_en[k]) |=> !pause[k]);
    end

endmodule

bind rx_fc_unit rxfc_checker #(
    .NUM_PAIRS (NUM_PAIRS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glob_en   (glob_en),
    .pair_en   (pair_en),
    .lo_thr    (lo_thr),
    .hi_thr    (hi_thr),
    .credit    (credit),
    .force_q   (force_q),
    .alloc_stb (alloc_stb),
    .desc_done (desc_done),
    .pause     (pause)
);

// File: tb/sim_rx_fc_unit.sv
module sim_rx_fc_unit;

    localparam int NP = 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NP-1:0] desc_done = '0;
    logic [NP-1:0] pause;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rx_fc_unit #(.NUM_PAIRS(NP), .CNT_W(8), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .desc_done(desc_done), .pause(pause)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input int addr, output logic [31:0] data);
        @(negedge clk);
        rd_addr = AW'(addr);
        #1 data = rd_data;
    endtask

    task automatic pulse_done(input int k, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            desc_done[k] = 1'b1;
            @(negedge clk);
            desc_done[k] = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 pause", 32'(pause), 32'h0);
        read_reg(0, v);  check("R1 cfg", v, 32'h0);
        read_reg(4, v);  check("R1 lo0", v, 32'h0);
        read_reg(12, v); check("R1 alloc0", v, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        write_reg(0, 32'h3);
        write_reg(4, 32'd2);
        write_reg(8, 32'd4);
        write_reg(16, 32'd7);
        read_reg(0, v);  check("R2 cfg readback", v, 32'h3);
        read_reg(4, v);  check("R2 lo0 readback", v, 32'd2);
        read_reg(8, v);  check("R2 hi0 readback", v, 32'd4);
        read_reg(16, v); check("R2 lo1 at 0x10", v, 32'd7);
    endtask

    task automatic t_hysteresis();
        logic [31:0] v;
        settle();
        check("R5 pause at zero credits", 32'(pause[0]), 32'd1);
        write_reg(12, 32'd3); settle();
        read_reg(12, v); check("R3 add three", v, 32'd3);
        check("R6 inside band holds pause", 32'(pause[0]), 32'd1);
        write_reg(12, 32'd1); settle();
        check("R6 equal high holds pause", 32'(pause[0]), 32'd1);
        write_reg(12, 32'd1); settle();
        check("R6 above high releases", 32'(pause[0]), 32'd0);
        pulse_done(0, 3); settle();
        read_reg(12, v); check("R4 three completions", v, 32'd2);
        check("R5 equal low no pause", 32'(pause[0]), 32'd0);
        pulse_done(0, 1); settle();
        check("R5 below low pauses", 32'(pause[0]), 32'd1);
        pulse_done(0, 3); settle();
        read_reg(12, v); check("R4 floor at zero", v, 32'd0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(12); wr_data = 32'd5; desc_done[0] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; desc_done[0] = 1'b0;
        settle();
        read_reg(12, v); check("R4 add and done together", v, 32'd4);
        check("R6 pause kept at high", 32'(pause[0]), 32'd1);
    endtask

    task automatic t_force();
        logic [31:0] v;
        write_reg(12, 32'h8000_0000); settle();
        check("R7 force opens", 32'(pause[0]), 32'd0);
        read_reg(12, v); check("R7 force flag and cleared count", v, 32'h8000_0000);
        pulse_done(0, 2); settle();
        read_reg(12, v); check("R7 done ignored", v, 32'h8000_0000);
        check("R7 pause stays open", 32'(pause[0]), 32'd0);
        write_reg(12, 32'd6); settle();
        read_reg(12, v); check("R3 add clears force", v, 32'd6);
        check("R3 flowing after force", 32'(pause[0]), 32'd0);
    endtask

    task automatic t_saturate();
        logic [31:0] v;
        write_reg(12, 32'd200);
        write_reg(12, 32'd100); settle();
        read_reg(12, v); check("R3 saturate at max", v, 32'd255);
    endtask

    task automatic t_disable();
        write_reg(12, 32'h8000_0000);
        write_reg(12, 32'd0); settle();
        check("R5 paused again at zero", 32'(pause[0]), 32'd1);
        write_reg(0, 32'h1); settle();
        check("R8 pair disable opens", 32'(pause[0]), 32'd0);
        write_reg(0, 32'h3); settle();
        check("R8 re-enable pauses", 32'(pause[0]), 32'd1);
        write_reg(0, 32'h2); settle();
        check("R8 global disable opens", 32'(pause[0]), 32'd0);
    endtask

    task automatic t_isolation();
        logic [31:0] v;
        write_reg(0, 32'h7);
        write_reg(16, 32'd3);
        write_reg(20, 32'd5);
        write_reg(24, 32'd10); settle();
        check("R9 pair1 flowing", 32'(pause[1]), 32'd0);
        check("R9 pair0 still paused", 32'(pause[0]), 32'd1);
        pulse_done(1, 1); settle();
        read_reg(24, v); check("R9 pair1 count", v, 32'd9);
        read_reg(12, v); check("R9 pair0 count unchanged", v, 32'd0);
        check("R9 pair0 pause unchanged", 32'(pause[0]), 32'd1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_hysteresis();
        t_force();
        t_saturate();
        t_disable();
        t_isolation();
        finish_run();
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule